// File: doc/BRIEF.md
# Tagged Round-Robin Stream Merger

This block gathers several independent 32-bit valid/ready streams and funnels them into one 32-bit output stream. Every input has its own small FIFO, so sources may all offer data in the same cycle and keep going while they wait for their turn. A round-robin arbiter takes one buffered word at a time and passes it on. The block writes the number of the input into the top bits of that word, so a receiver can sort the merged words back into their streams.

The output stage is a register. It takes a new word whenever it is empty or its current word leaves in the same cycle. With enough queued data and a sink that never stalls, it delivers one word per clock. There is no packet framing, and arbitration works word by word. The header is `HDR_W = ceil(log2(NUM_SRC))` bits wide and sits at the top of the word. The payload takes the low `DATA_W - HDR_W` bits, and any input bits that fall in the header field are dropped.

Top module: `tag_stream_merger`

## Requirements
- R1: After synchronous reset, `m_tvalid` is low, every bit of `s_tready` is high, all FIFOs are empty, and the round-robin search starts at input 0.
- R2: An input word enters a FIFO only in a cycle where both its valid and ready are high. A word leaves the output only where `m_tvalid` and `m_tready` are both high. Input data driven while valid is low has no effect.
- R3: An input's ready is high exactly when its FIFO (depth `FIFO_DEPTH`, default 4) is not full. With the output stalled, a single input therefore accepts `FIFO_DEPTH + 1` words before its ready drops. Other inputs are not affected.
- R4: Words from one input leave in the order they arrived.
- R5: Once `m_tvalid` is high, it stays high until a cycle in which `m_tready` is high.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tdata` does not change.
- R7: Each output word is `{src_id, payload}`. With the defaults, bits [31:30] hold the input index (0 to 3) and bits [29:0] hold bits [29:0] of the input word. Input bits [31:30] are discarded.
- R8: The arbiter searches starting at the input after the most recently granted one, skips inputs whose FIFO is empty, and wraps from input `NUM_SRC-1` to input 0.
- R9: When no FIFO holds data and the output word has been taken, `m_tvalid` is low.
- R10: While `m_tready` stays high and buffered data remains, the output delivers one word in every cycle, with no idle cycles.
- R11: Several inputs may each deliver a word in the same cycle, and all of those words are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tdata | input | NUM_SRC*DATA_W | Input words; input i uses bits [i*DATA_W +: DATA_W] |
| s_tvalid | input | NUM_SRC | Per-input valid, driven by the source |
| s_tready | output | NUM_SRC | Per-input ready, high while that FIFO has space |
| m_tdata | output | DATA_W | Merged output word with the source header in the top bits |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready, driven by the sink |

## Verification
Two functions can fall in the same clock edge. The output register may be unloaded by the sink while it is reloaded from a FIFO, and one FIFO may be written by its source while the arbiter pops it. The bench provokes both cases in two steps. First, all four inputs are filled in one cycle while the output is stalled. Then `m_tready` is held high so the queued words stream out. The bench judges the result by requiring a valid word at every sampled cycle, in the round-robin order it predicts from the last grant. A further test keeps one source pushing against a stalled sink and counts how many words it accepts before its ready drops.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

   // Width of the source-index header for a given number of inputs.
   function automatic int hdr_width(input int n_src);
      return (n_src > 1) ? $clog2(n_src) : 1;
   endfunction

endpackage

// File: rtl/tsm_fifo.sv
module tsm_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          not_full,
   output logic          not_empty
);
   localparam int  PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tsm_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign not_full  = (count != CW'(DEPTH));
   assign not_empty = (count != '0);
   assign do_push   = push && not_full;
   assign do_pop    = pop && not_empty;
   assign rdata     = mem[rd_ptr];

   // Pointer wrap: natural for power-of-two depth, compared otherwise.
   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/tsm_rr_arb.sv
module tsm_rr_arb #(
   parameter int NUM_SRC = 4,
   parameter int IW      = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] req,
   input  logic               advance,
   output logic [IW-1:0]      gnt_id,
   output logic               any
);
   logic [IW-1:0] start_q;
   logic [IW-1:0] cand;

   // Walk offsets from far to near so the nearest requester wins.
   always_comb begin
      gnt_id = '0;
      any    = 1'b0;
      cand   = '0;
      for (int off = NUM_SRC - 1; off >= 0; off--) begin
         cand = IW'((int'(start_q) + off) % NUM_SRC);
         if (req[cand]) begin
            gnt_id = cand;
            any    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         start_q <= '0;
      end else if (advance) begin
         start_q <= (gnt_id == IW'(NUM_SRC - 1)) ? '0 : gnt_id + 1'b1;
      end
   end
endmodule

// File: rtl/tsm_out_stage.sv
module tsm_out_stage #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [DW-1:0] word,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk) begin
      if (rst)        valid <= 1'b0;
      else if (load)  valid <= 1'b1;
      else if (ready) valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load) data <= word;
   end
endmodule

// File: rtl/tag_stream_merger.sv
module tag_stream_merger #(
   parameter int NUM_SRC    = 4,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_SRC*DATA_W-1:0] s_tdata,
   input  logic [NUM_SRC-1:0]        s_tvalid,
   output logic [NUM_SRC-1:0]        s_tready,
   output logic [DATA_W-1:0]         m_tdata,
   output logic                      m_tvalid,
   input  logic                      m_tready
);
   localparam int HDR_W = tsm_pkg::hdr_width(NUM_SRC);
   localparam int PAY_W = DATA_W - HDR_W;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("tag_stream_merger: NUM_SRC must be at least 2");
   end
   if (PAY_W < 1) begin : g_bad_width
      $error("tag_stream_merger: DATA_W too small for the header");
   end

   logic [NUM_SRC-1:0] has_data;
   logic [NUM_SRC-1:0] pop_vec;
   logic [DATA_W-1:0]  head [NUM_SRC];
   logic [HDR_W-1:0]   gnt_id;
   logic               any_req;
   logic               load;
   logic [DATA_W-1:0]  stamped;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      tsm_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk       (clk),
         .rst       (rst),
         .push      (s_tvalid[i]),
         .wdata     (s_tdata[i*DATA_W +: DATA_W]),
         .pop       (pop_vec[i]),
         .rdata     (head[i]),
         .not_full  (s_tready[i]),
         .not_empty (has_data[i])
      );
      assign pop_vec[i] = load && (gnt_id == HDR_W'(i));
   end

   tsm_rr_arb #(.NUM_SRC(NUM_SRC), .IW(HDR_W)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (has_data),
      .advance (load),
      .gnt_id  (gnt_id),
      .any     (any_req)
   );

   // Reload when the output register is free or is emptied this cycle.
   assign load    = any_req && (!m_tvalid || m_tready);
   assign stamped = {gnt_id, head[gnt_id][PAY_W-1:0]};

   tsm_out_stage #(.DW(DATA_W)) u_out (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .word  (stamped),
      .ready (m_tready),
      .valid (m_tvalid),
      .data  (m_tdata)
   );
endmodule

// File: rtl/tag_stream_merger_chk.sv
module tag_stream_merger_chk #(
   parameter int NUM_SRC = 4,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] s_tvalid,
   input logic [NUM_SRC-1:0] s_tready,
   input logic [DATA_W-1:0]  m_tdata,
   input logic               m_tvalid,
   input logic               m_tready,
   input logic [NUM_SRC-1:0] pop_vec
);
   p_reset_idle_r1: assert property (@(posedge clk) rst |=> !m_tvalid);

   p_valid_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> m_tvalid);

   p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> $stable(m_tdata));

   p_single_pop_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(pop_vec));

   p_pop_fills_out_r10: assert property (@(posedge clk) disable iff (rst)
      (|pop_vec) |=> m_tvalid);

   p_drop_after_take_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(m_tvalid) |-> $past(m_tready));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_in
      p_full_after_push_r3: assert property (@(posedge clk) disable iff (rst)
         $fell(s_tready[i]) |-> $past(s_tvalid[i] && s_tready[i]));
   end
endmodule

bind tag_stream_merger tag_stream_merger_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .s_tvalid (s_tvalid),
   .s_tready (s_tready),
   .m_tdata  (m_tdata),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .pop_vec  (pop_vec)
);

// File: tb/tag_stream_merger_test.sv
module tag_stream_merger_test;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int N  = 4;
   localparam int DW = 32;
   localparam int DP = 4;

   logic            clk = 1'b0;
   logic            rst;
   logic [N*DW-1:0] s_tdata;
   logic [N-1:0]    s_tvalid;
   logic [N-1:0]    s_tready;
   logic [DW-1:0]   m_tdata;
   logic            m_tvalid;
   logic            m_tready;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   int last_src;

   // {source index, input word}
   localparam logic [33:0] VEC [8] = '{
      {2'd0, 32'hC000_0001}, {2'd1, 32'hFFFF_FFFF},
      {2'd2, 32'h4000_1234}, {2'd3, 32'h1234_5678},
      {2'd2, 32'h8000_0000}, {2'd2, 32'h0000_0000},
      {2'd0, 32'hDEAD_BEEF}, {2'd1, 32'h7FFF_FFFF}
   };

   always #2.5 clk = ~clk;

   tag_stream_merger #(.NUM_SRC(N), .DATA_W(DW), .FIFO_DEPTH(DP)) uut (
      .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
      .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
      .m_tready(m_tready)
   );

   function automatic logic [31:0] stamp(input int src, input logic [31:0] w);
      return {src[1:0], w[29:0]};
   endfunction

   function automatic int next_rr(input int last, input logic [N-1:0] mask);
      for (int k = 1; k <= N; k++)
         if (mask[(last + k) % N]) return (last + k) % N;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_one(input int src, input logic [31:0] w);
      @(posedge clk); #1;
      s_tdata[src*DW +: DW] = w;
      s_tvalid[src] = 1'b1;
      @(negedge clk);
      while (!s_tready[src]) @(negedge clk);
      @(posedge clk); #1;
      s_tvalid[src] = 1'b0;
   endtask

   task automatic pop_one(input logic [31:0] exp, input string req);
      @(negedge clk);
      while (!m_tvalid) @(negedge clk);
      check(m_tdata == exp, req, m_tdata, exp);
      m_tready = 1'b1;
      @(posedge clk); #1;
      m_tready = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      s_tdata  = '0;
      s_tvalid = '0;
      m_tready = 1'b0;
      do_reset();

      // R1: reset state
      @(negedge clk);
      check(!m_tvalid, "R1 idle after reset", 32'(m_tvalid), 0);
      check(s_tready == '1, "R1 ready after reset", 32'(s_tready), 32'hF);

      // R2: data with valid low is ignored
      s_tdata = '1;
      repeat (3) @(negedge clk);
      check(!m_tvalid, "R2 no transfer without valid", 32'(m_tvalid), 0);
      s_tdata = '0;

      // Table walk: R7 header stamping and payload masking, R9 idle
      last_src = N - 1;
      for (int k = 0; k < 8; k++) begin
         int src;
         src = int'(VEC[k][33:32]);
         push_one(src, VEC[k][31:0]);
         pop_one(stamp(src, VEC[k][31:0]), "R7 stamped word");
         @(negedge clk);
         check(!m_tvalid, "R9 idle after drain", 32'(m_tvalid), 0);
         last_src = src;
      end

      // R11 simultaneous pushes, then R8 order and R10 back-to-back
      @(posedge clk); #1;
      for (int s = 0; s < N; s++) s_tdata[s*DW +: DW] = 32'hA000_0000 | 32'(s);
      s_tvalid = '1;
      @(negedge clk);
      check(s_tready == '1, "R11 all inputs ready together", 32'(s_tready), 32'hF);
      @(posedge clk); #1;
      s_tvalid = '0;
      @(posedge clk); #1;
      m_tready = 1'b1;
      for (int k = 0; k < N; k++) begin
         int exp_src;
         exp_src = (last_src + 1 + k) % N;
         @(negedge clk);
         check(m_tvalid, "R10 no bubble", 32'(m_tvalid), 1);
         check(m_tdata == stamp(exp_src, 32'hA000_0000 | 32'(exp_src)),
               "R8 round-robin order", m_tdata,
               stamp(exp_src, 32'hA000_0000 | 32'(exp_src)));
      end
      @(negedge clk);
      check(!m_tvalid, "R9 idle after burst", 32'(m_tvalid), 0);
      m_tready = 1'b0;
      last_src = (last_src + N) % N;

      // R5 / R6: stalled output holds valid and data
      begin
         logic [31:0] held;
         push_one(2, 32'h5555_AAAA);
         @(negedge clk);
         while (!m_tvalid) @(negedge clk);
         held = m_tdata;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(m_tvalid, "R5 valid held under stall", 32'(m_tvalid), 1);
            check(m_tdata == held, "R6 data held under stall", m_tdata, held);
         end
         pop_one(stamp(2, 32'h5555_AAAA), "R7 stalled word");
         last_src = 2;
      end

      // R8: empty inputs skipped (start after 2 -> 3 is empty -> 0 then 1)
      @(posedge clk); #1;
      s_tdata[0*DW +: DW] = 32'h0000_0A0A;
      s_tdata[1*DW +: DW] = 32'h0000_0B0B;
      s_tvalid = 4'b0011;
      @(posedge clk); #1;
      s_tvalid = '0;
      begin
         int first;
         first = next_rr(last_src, 4'b0011);
         pop_one(stamp(first, (first == 0) ? 32'h0A0A : 32'h0B0B), "R8 skip empty");
         pop_one(stamp(1 - first, (first == 0) ? 32'h0B0B : 32'h0A0A), "R8 skip empty second");
         last_src = 1 - first;
      end

      // R3 / R4: fill input 0 against a stalled output
      begin
         int acc;
         acc = 0;
         @(posedge clk); #1;
         s_tdata[0*DW +: DW] = 32'h100;
         s_tvalid[0] = 1'b1;
         for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (!s_tready[0]) break;
            @(posedge clk); #1;
            acc++;
            s_tdata[0*DW +: DW] = 32'h100 + 32'(acc);
         end
         s_tvalid[0] = 1'b0;
         check(acc == DP + 1, "R3 words accepted before full", 32'(acc), 32'(DP + 1));
         check(s_tready[1], "R3 other input unaffected", 32'(s_tready[1]), 1);
         for (int k = 0; k < DP + 1; k++)
            pop_one(stamp(0, 32'h100 + 32'(k)), "R4 FIFO order");
         @(negedge clk);
         check(s_tready[0], "R3 ready after drain", 32'(s_tready[0]), 1);
      end

      // R1: reset mid-traffic clears data and restarts search at input 0
      push_one(3, 32'h0000_3333);
      @(negedge clk);
      while (!m_tvalid) @(negedge clk);
      do_reset();
      @(negedge clk);
      check(!m_tvalid, "R1 reset drops output", 32'(m_tvalid), 0);
      check(s_tready == '1, "R1 reset empties FIFOs", 32'(s_tready), 32'hF);
      @(posedge clk); #1;
      for (int s = 0; s < N; s++) s_tdata[s*DW +: DW] = 32'h0000_0C00 | 32'(s);
      s_tvalid = '1;
      @(posedge clk); #1;
      s_tvalid = '0;
      pop_one(stamp(0, 32'h0C00), "R1 first grant is input 0");
      for (int s = 1; s < N; s++)
         pop_one(stamp(s, 32'h0C00 | 32'(s)), "R8 order after reset");
      @(negedge clk);
      check(!m_tvalid, "R9 idle at end", 32'(m_tvalid), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule